// File: doc/BRIEF.md
# Bus Mastership Claim Sequencer

This block lets an on-chip engine become master of an asynchronous, strobe-based microprocessor bus. That bus shares ownership through three wires: a wired-OR request, a grant and a grant acknowledge. An internal request line starts the sequence. The block then pulls the shared request line low and waits until the arbiter grants the bus. It takes the bus only when the cycle in progress has ended, no other device holds the acknowledge line, and the bus error code shows the normal mode. At that point it drives the acknowledge line low. It keeps ownership until the engine signals that it has finished. It then releases the acknowledge line and returns to idle.

Every bus-side input is asynchronous, so each one passes through a multi-stage synchronizer before the control logic acts on it. The open-drain request and the three-state acknowledge are each brought out as an enable and a data value. The pull-ups sit outside the block. The block also watches its own chip select. If the host selects the block's registers while the block owns the bus, the block issues a one-cycle address error pulse.

Top module: `bus_master_claim`

## Requirements
- R1: After reset the request enable, the acknowledge enable, the master flag and the address error output are all 0.
- R2: When the internal request is high in the idle state, the request enable goes to 1 at the next rising clock edge, which pulls the request line (active low) to 0.
- R3: While the grant input (active low) stays 1, mastership is never claimed, however long the request is held.
- R4: While the address strobe input (active low) is 0, mastership is never claimed.
- R5: While another device holds the acknowledge line at 0, mastership is never claimed.
- R6: While the 3-bit error code is anything other than 3'b000, mastership is never claimed.
- R7: Once all claim conditions hold, the acknowledge enable and the master flag rise, and the request enable falls, on a fixed edge. With a two-stage synchronizer this is the 3rd rising edge after the last address strobe, acknowledge or error-code change. It is the 4th rising edge after a late grant. While the block is master it drives the acknowledge data as 0.
- R8: An internal done sampled while the block is master clears the acknowledge enable and the master flag at that same edge. The block is back in idle one edge later.
- R9: Dropping the internal request before mastership, either before or after the grant, clears the request enable at the next edge, and no claim follows.
- R10: A falling chip select (active low) seen while the block is master produces exactly one address error pulse, one cycle wide, on the 3rd rising edge after the fall. A chip select held low gives no further pulses, and a chip select while not master gives none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| take_req_i | input | 1 | Internal request for bus ownership |
| take_done_i | input | 1 | Internal end of ownership |
| bus_grant_n_i | input | 1 | Arbiter grant, active low, asynchronous |
| bus_gack_n_i | input | 1 | Acknowledge line as seen on the bus, active low |
| bus_strobe_n_i | input | 1 | Address strobe, active low, asynchronous |
| bus_ecode_i | input | 3 | Bus error code; 3'b000 is normal mode |
| host_sel_n_i | input | 1 | Register chip select, active low, asynchronous |
| req_oe_o | output | 1 | Enable that pulls the wired-OR request line low |
| gack_oe_o | output | 1 | Output enable of the acknowledge line |
| gack_do_o | output | 1 | Data driven on the acknowledge line when enabled |
| is_master_o | output | 1 | Block currently owns the bus |
| addr_err_o | output | 1 | One-cycle address error pulse |

## Verification
The hardest case to reach from the ports is a claim blocked by exactly one missing condition while all the others are already true and settled through the synchronizer. Reaching it requires holding the block in its request or wait phase for many cycles. The stimulus does this for each blocker in turn: it keeps only that one condition false for ten cycles and checks every cycle that the block makes no claim. It then clears that condition and expects the claim on the exact edge implied by the synchronizer depth. The address error case needs real mastership first, so the chip select is pulsed only after a complete claim.

// File: rtl/bmc_pkg.sv
package bmc_pkg;

  localparam int ECODE_W = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQUEST,
    ST_WAIT_FREE,
    ST_MASTER,
    ST_RELEASE
  } arb_state_t;

  // error code check against the configured normal value
  function automatic logic ecode_is_normal(input logic [ECODE_W-1:0] code,
                                           input logic [ECODE_W-1:0] normal);
    return code == normal;
  endfunction

  // bus may be taken: no cycle running, no other owner, code normal
  function automatic logic bus_is_free(input logic strobe_busy,
                                       input logic other_owner,
                                       input logic code_ok);
    return !strobe_busy && !other_owner && code_ok;
  endfunction

endpackage

// File: rtl/bmc_sync.sv
module bmc_sync #(
  parameter int          W      = 1,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] RST_V = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_V;
    end else begin
      stg[0] <= async_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign sync_o = stg[STAGES-1];

endmodule

// File: rtl/bmc_fsm.sv
module bmc_fsm
  import bmc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic take_req_i,
  input  logic take_done_i,
  input  logic grant_s_i,
  input  logic free_s_i,
  input  logic other_s_i,
  output logic req_oe_o,
  output logic gack_oe_o,
  output logic gack_do_o,
  output logic is_master_o
);

  arb_state_t st, st_nx;

  // named events for checks
  logic claim_w, release_w, withdraw_w;
  assign claim_w    = (st == ST_WAIT_FREE) && take_req_i && free_s_i;
  assign release_w  = (st == ST_MASTER) && take_done_i;
  assign withdraw_w = ((st == ST_REQUEST) || (st == ST_WAIT_FREE)) && !take_req_i;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE:      if (take_req_i) st_nx = ST_REQUEST;
      ST_REQUEST:   if (withdraw_w) st_nx = ST_IDLE;
                    else if (grant_s_i) st_nx = ST_WAIT_FREE;
      ST_WAIT_FREE: if (withdraw_w) st_nx = ST_IDLE;
                    else if (claim_w) st_nx = ST_MASTER;
      ST_MASTER:    if (release_w) st_nx = ST_RELEASE;
      ST_RELEASE:   st_nx = ST_IDLE;
      default:      st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end

  assign req_oe_o    = (st == ST_REQUEST) || (st == ST_WAIT_FREE);
  assign gack_oe_o   = (st == ST_MASTER);
  assign gack_do_o   = (st != ST_MASTER);
  assign is_master_o = (st == ST_MASTER);

  // R7: a claim only follows a cycle in which the bus was free and requested
  a_r7_claim_needs_free: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gack_oe_o) |-> $past(free_s_i) && $past(req_oe_o) && $past(take_req_i));

  // R3: no grant while requesting means no claim next cycle
  a_r3_no_claim_without_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_REQUEST) |=> !gack_oe_o);

  // R5: another owner on the acknowledge line blocks the claim
  a_r5_other_owner_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (req_oe_o && other_s_i) |=> !gack_oe_o);

  // R7: request and acknowledge are never driven together
  a_r7_req_ack_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_oe_o && gack_oe_o));

  // R8: done while master releases the acknowledge at once
  a_r8_release_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    release_w |=> !gack_oe_o && !req_oe_o);

  // R9: withdrawn request drops the request line
  a_r9_withdraw: assert property (@(posedge clk) disable iff (!rst_n)
    withdraw_w |=> !req_oe_o && !gack_oe_o);

endmodule

// File: rtl/bmc_addr_err.sv
module bmc_addr_err (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_s_i,
  input  logic is_master_i,
  output logic addr_err_o
);

  logic sel_q;
  logic sel_rise_w;

  assign sel_rise_w = sel_s_i && !sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q      <= 1'b0;
      addr_err_o <= 1'b0;
    end else begin
      sel_q      <= sel_s_i;
      addr_err_o <= sel_rise_w && is_master_i;
    end
  end

  // R10: the error is a single-cycle pulse
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err_o |=> !addr_err_o);

  // R10: an error only follows a select seen during mastership
  a_r10_only_when_master: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_err_o) |-> $past(is_master_i) && $past(sel_s_i));

endmodule

// File: rtl/bus_master_claim.sv
module bus_master_claim
  import bmc_pkg::*;
#(
  parameter int                  SYNC_STAGES = 2,
  parameter logic [ECODE_W-1:0]  ECODE_NORM  = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take_req_i,
  input  logic               take_done_i,
  input  logic               bus_grant_n_i,
  input  logic               bus_gack_n_i,
  input  logic               bus_strobe_n_i,
  input  logic [ECODE_W-1:0] bus_ecode_i,
  input  logic               host_sel_n_i,
  output logic               req_oe_o,
  output logic               gack_oe_o,
  output logic               gack_do_o,
  output logic               is_master_o,
  output logic               addr_err_o
);

  localparam int SW = 4 + ECODE_W;
  localparam logic [SW-1:0] SYNC_RST = {4'b1111, ~ECODE_NORM};

  logic [SW-1:0] raw_w, syn_w;
  assign raw_w = {bus_grant_n_i, bus_gack_n_i, bus_strobe_n_i, host_sel_n_i, bus_ecode_i};

  bmc_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_V(SYNC_RST)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (raw_w),
    .sync_o  (syn_w)
  );

  logic grant_s, other_s, strobe_busy_s, sel_s, code_ok_s, free_s;
  assign grant_s       = !syn_w[SW-1];
  assign other_s       = !syn_w[SW-2];
  assign strobe_busy_s = !syn_w[SW-3];
  assign sel_s         = !syn_w[SW-4];
  assign code_ok_s     = ecode_is_normal(syn_w[ECODE_W-1:0], ECODE_NORM);
  assign free_s        = bus_is_free(strobe_busy_s, other_s, code_ok_s);

  bmc_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .take_req_i  (take_req_i),
    .take_done_i (take_done_i),
    .grant_s_i   (grant_s),
    .free_s_i    (free_s),
    .other_s_i   (other_s),
    .req_oe_o    (req_oe_o),
    .gack_oe_o   (gack_oe_o),
    .gack_do_o   (gack_do_o),
    .is_master_o (is_master_o)
  );

  bmc_addr_err u_aerr (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_s_i     (sel_s),
    .is_master_i (is_master_o),
    .addr_err_o  (addr_err_o)
  );

  // R4/R6: a claim only happens with the strobe idle and the code normal
  a_r4_r6_claim_bus_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(is_master_o) |-> $past(!strobe_busy_s) && $past(code_ok_s));

  // R7: acknowledge data is low whenever it is driven
  a_r7_drive_low: assert property (@(posedge clk) disable iff (!rst_n)
    gack_oe_o |-> !gack_do_o);

endmodule

// File: tb/sim_bus_master_claim.sv
module sim_bus_master_claim;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic take_req = 1'b0, take_done = 1'b0;
  logic grant_n = 1'b1, strobe_n = 1'b1, sel_n = 1'b1, other_drv = 1'b0;
  logic [2:0] ecode = 3'b000;
  logic req_oe, gack_oe, gack_do, is_master, addr_err;
  logic req_line, gack_line;

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  // wired bus with pull-ups
  assign req_line  = req_oe ? 1'b0 : 1'b1;
  assign gack_line = (gack_oe ? gack_do : 1'b1) & ~other_drv;

  bus_master_claim u0 (
    .clk            (clk),
    .rst_n          (rst_n),
    .take_req_i     (take_req),
    .take_done_i    (take_done),
    .bus_grant_n_i  (grant_n),
    .bus_gack_n_i   (gack_line),
    .bus_strobe_n_i (strobe_n),
    .bus_ecode_i    (ecode),
    .host_sel_n_i   (sel_n),
    .req_oe_o       (req_oe),
    .gack_oe_o      (gack_oe),
    .gack_do_o      (gack_do),
    .is_master_o    (is_master),
    .addr_err_o     (addr_err)
  );

  typedef struct {
    string tag;
    logic  req_n;
    logic  ack;
    logic  mst;
    logic  err;
  } exp_t;

  exp_t sb[$];

  task automatic push(input string tag, input logic rq_n, input logic ack,
                      input logic mst, input logic err);
    exp_t e;
    e.tag = tag; e.req_n = rq_n; e.ack = ack; e.mst = mst; e.err = err;
    sb.push_back(e);
  endtask

  // monitor: compares queued expectations away from the clock edge
  always @(negedge clk) begin
    #1;
    while (sb.size() > 0) begin
      exp_t e;
      logic ack_ok;
      e = sb.pop_front();
      n_run++;
      ack_ok = (gack_oe == e.ack) && (!e.ack || gack_line == 1'b0);
      if (req_line !== e.req_n || !ack_ok || is_master !== e.mst || addr_err !== e.err) begin
        n_fail++;
        $display("FAIL %s: got req_n=%b ack_oe=%b gack=%b mst=%b err=%b exp req_n=%b ack_oe=%b mst=%b err=%b",
                 e.tag, req_line, gack_oe, gack_line, is_master, addr_err,
                 e.req_n, e.ack, e.mst, e.err);
      end
    end
  end

  // which: 0 grant late (R3), 1 strobe busy (R4), 2 other owner (R5), 3 bad code (R6)
  task automatic blocked_claim(input string tag, input int which);
    int lat;
    take_req  = 1'b1;
    grant_n   = (which == 0);
    strobe_n  = (which != 1);
    other_drv = (which == 2);
    ecode     = (which == 3) ? 3'b101 : 3'b000;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      push(tag, 1'b0, 1'b0, 1'b0, 1'b0);
    end
    grant_n = 1'b0; strobe_n = 1'b1; other_drv = 1'b0; ecode = 3'b000;
    lat = (which == 0) ? 4 : 3;
    for (int i = 1; i <= lat; i++) begin
      @(negedge clk);
      if (i < lat) push("R7 before claim edge", 1'b0, 1'b0, 1'b0, 1'b0);
      else         push("R7 claim edge", 1'b1, 1'b1, 1'b1, 1'b0);
    end
  endtask

  task automatic end_master();
    take_done = 1'b1;
    @(negedge clk);
    push("R8 release at done edge", 1'b1, 1'b0, 1'b0, 1'b0);
    take_done = 1'b0; take_req = 1'b0; grant_n = 1'b1;
    @(negedge clk);
    push("R8 idle after release", 1'b1, 1'b0, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    push("R1 reset state", 1'b1, 1'b0, 1'b0, 1'b0);

    // R2 + R9: request then withdraw before grant
    take_req = 1'b1;
    @(negedge clk);
    push("R2 request driven", 1'b0, 1'b0, 1'b0, 1'b0);
    take_req = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      push("R9 withdraw before grant", 1'b1, 1'b0, 1'b0, 1'b0);
    end

    // R9: withdraw after grant while strobe busy
    take_req = 1'b1; grant_n = 1'b0; strobe_n = 1'b0;
    repeat (6) @(negedge clk);
    take_req = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      push("R9 withdraw after grant", 1'b1, 1'b0, 1'b0, 1'b0);
    end
    grant_n = 1'b1; strobe_n = 1'b1;
    repeat (4) @(negedge clk);

    blocked_claim("R3 no grant", 0);    end_master();
    blocked_claim("R4 strobe busy", 1); end_master();
    blocked_claim("R5 other owner", 2); end_master();
    blocked_claim("R6 error code", 3);

    // R10: select while master
    sel_n = 1'b0;
    for (int i = 1; i <= 7; i++) begin
      @(negedge clk);
      push("R10 select while master", 1'b1, 1'b1, 1'b1, (i == 3));
    end
    sel_n = 1'b1;
    repeat (3) @(negedge clk);
    end_master();

    // R10: select while idle
    sel_n = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      push("R10 select while idle", 1'b1, 1'b0, 1'b0, 1'b0);
    end
    sel_n = 1'b1;

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule